// File: doc/BRIEF.md
# Keypad Tone Pair Classifier

This block identifies a telephone keypad digit from two square-wave tone signals. One signal has already been band-split and squared to the low frequency group and the other to the high group. For each group the block counts reference clocks between rising edges and adds four consecutive periods together. It then compares that sum against a tolerance window around each of the four standard frequencies of the group.

When both groups hold an accepted frequency at the same time, the block raises an early-signal flag and presents a fixed 4-bit digit code. Any loss of either group clears the flag at once. A group is lost when its sum falls outside every window, when it moves to a different frequency, or when it times out.

The reference clock rate is a parameter, and every window and timeout is derived from it at elaboration time. Downstream steering logic takes the flag and the code and applies its own duration checks.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: After a synchronous reset, and with no tone present, `early_o` is low.
- R2: While `early_o` is high, `digit_code_o` depends on the low-group frequency (697, 770, 852, 941 Hz) and the high-group frequency (1209, 1336, 1477, 1633 Hz).
  - With 697 Hz, the 1209/1336/1477/1633 Hz columns give 0001/0010/0011/1101.
  - With 770 Hz they give 0100/0101/0110/1110.
  - With 852 Hz they give 0111/1000/1001/1111.
  - With 941 Hz they give 1011/1010/1100/0000.
- R3: `early_o` is high only while both groups hold an accepted frequency. A tone on one group alone never raises it.
- R4: A group is accepted when the sum S of four consecutive edge-to-edge periods, in reference clocks, satisfies ceil(4·CLK_HZ·975/(1000·f)) ≤ S ≤ floor(4·CLK_HZ·1025/(1000·f)) for one nominal f. That is a ±2.5 % window. A sum one step outside the window is rejected.
- R5: A group becomes valid only after one arming edge and then four complete periods. A tone burst shorter than that never raises `early_o`.
- R6: If a valid group sees no rising edge for 2·CLK_HZ/f_min reference clocks, where f_min is the lowest frequency of that group, the group becomes invalid and `early_o` drops.
- R7: `digit_code_o` does not change while `early_o` stays high. If a group's accepted frequency changes to another nominal value, `early_o` first falls, then rises again with the new code.
- R8: The tolerance windows of one group are disjoint, so at most one band matches any sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_low_i | input | 1 | Squared low-group tone (asynchronous) |
| tone_high_i | input | 1 | Squared high-group tone (asynchronous) |
| digit_code_o | output | 4 | Digit code, meaningful while early_o is high |
| early_o | output | 1 | Both groups hold accepted frequencies |

## Verification
The bench sweeps all sixteen frequency pairs at their nominal periods and checks each code, so a swapped row or column entry shows up as a wrong code. It drives periods one clock inside and one clock outside each edge of a window. An off-by-one bound or a wrongly rounded window would accept the outer period or reject the inner one.

Short bursts, a single-group tone and a tone that stops all show whether the flag rises too early or lingers after loss. A frequency change in mid-signal shows whether a design lets the code slide while the flag stays high.

// File: rtl/dtmf_cls_pkg.sv
// Shared constants and arithmetic for the keypad tone pair classifier.
// Assumes frequencies are integer hertz and windows are computed at elaboration.
package dtmf_cls_pkg;

    // Nominal low-group frequency for band index 0..3
    function automatic int unsigned low_hz(input int unsigned b);
        case (b)
            0: return 697;
            1: return 770;
            2: return 852;
            default: return 941;
        endcase
    endfunction

    // Nominal high-group frequency for band index 0..3
    function automatic int unsigned high_hz(input int unsigned b);
        case (b)
            0: return 1209;
            1: return 1336;
            2: return 1477;
            default: return 1633;
        endcase
    endfunction

    // Smallest accepted sum of AVG periods (ceiling of lower tolerance edge)
    function automatic longint unsigned win_lo(input longint unsigned clk_hz,
                                               input longint unsigned hz,
                                               input longint unsigned avg,
                                               input longint unsigned tol);
        return (avg * clk_hz * (1000 - tol) + 1000 * hz - 1) / (1000 * hz);
    endfunction

    // Largest accepted sum of AVG periods (floor of upper tolerance edge)
    function automatic longint unsigned win_hi(input longint unsigned clk_hz,
                                               input longint unsigned hz,
                                               input longint unsigned avg,
                                               input longint unsigned tol);
        return (avg * clk_hz * (1000 + tol)) / (1000 * hz);
    endfunction

    // Digit code for a (low row, high column) band pair
    function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
        if (col == 2'd3)
            return 4'(4'd13 + {2'b00, row});
        else if (row != 2'd3)
            return 4'(3 * row + col + 1);
        else if (col == 2'd0)
            return 4'b1011;
        else if (col == 2'd1)
            return 4'b1010;
        else
            return 4'b1100;
    endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
// Measures one squared tone: synchronises it, counts reference clocks between
// rising edges and emits the sum of 2**AVG_LOG2 consecutive periods as a strobe.
// Assumes TIMEOUT fits in W-AVG_LOG2 bits; the first edge after reset or timeout only arms.
module dtmf_period_meter #(
    parameter int unsigned TIMEOUT  = 2869,
    parameter int unsigned AVG_LOG2 = 2,
    parameter int unsigned W        = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tone_i,
    output logic [W-1:0] sum_o,
    output logic         strobe_o,
    output logic         timeout_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 2);

    logic [2:0]          sync_q;
    logic                rise;
    logic [CNT_W-1:0]    cnt_q;
    logic                armed_q;
    logic [W-1:0]        acc_q;
    logic [AVG_LOG2-1:0] k_q;
    logic [W-1:0]        period;

    assign rise   = sync_q[1] & ~sync_q[2];
    assign period = W'(cnt_q) + W'(1);

    // Two-stage synchroniser plus previous-value stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tone_i};
    end

    // Period counting, accumulation over the averaging block, and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            acc_q     <= '0;
            k_q       <= '0;
            sum_o     <= '0;
            strobe_o  <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            strobe_o  <= 1'b0;
            timeout_o <= 1'b0;
            if (rise) begin
                cnt_q <= '0;
                if (!armed_q) begin
                    armed_q <= 1'b1;
                    acc_q   <= '0;
                    k_q     <= '0;
                end else if (&k_q) begin
                    sum_o    <= acc_q + period;
                    strobe_o <= 1'b1;
                    acc_q    <= '0;
                    k_q      <= '0;
                end else begin
                    acc_q <= acc_q + period;
                    k_q   <= k_q + 1'b1;
                end
            end else if (cnt_q == CNT_W'(TIMEOUT)) begin
                if (armed_q) timeout_o <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtmf_band_classifier.sv
// Compares each averaged period sum against four tolerance windows of one group
// and keeps the accepted band index. A new match on a different band drops
// validity first, so the index never changes while the group stays valid.
module dtmf_band_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 1000000,
    parameter bit          IS_HIGH      = 1'b0,
    parameter int unsigned AVG_LOG2     = 2,
    parameter int unsigned TOL_PERMILLE = 25,
    parameter int unsigned W            = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sum_i,
    input  logic         strobe_i,
    input  logic         timeout_i,
    output logic [3:0]   hit_o,
    output logic         valid_o,
    output logic [1:0]   idx_o
);
    localparam longint unsigned AVG = 64'd1 << AVG_LOG2;

    logic [1:0] hit_idx;

    for (genvar b = 0; b < 4; b++) begin : g_band
        localparam longint unsigned HZ = IS_HIGH ? 64'(high_hz(b)) : 64'(low_hz(b));
        localparam longint unsigned LO = win_lo(64'(CLK_HZ), HZ, AVG, 64'(TOL_PERMILLE));
        localparam longint unsigned HI = win_hi(64'(CLK_HZ), HZ, AVG, 64'(TOL_PERMILLE));
        assign hit_o[b] = (64'(sum_i) >= LO) && (64'(sum_i) <= HI);
    end

    // Encode the matching band number
    always_comb begin
        hit_idx = 2'd0;
        for (int b = 0; b < 4; b++)
            if (hit_o[b]) hit_idx = 2'(b);
    end

    // Acceptance state: acquire, hold, or drop on miss, change or timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            idx_o   <= 2'd0;
        end else if (timeout_i) begin
            valid_o <= 1'b0;
        end else if (strobe_i) begin
            if (hit_o == 4'b0000) begin
                valid_o <= 1'b0;
            end else if (!valid_o) begin
                valid_o <= 1'b1;
                idx_o   <= hit_idx;
            end else if (idx_o != hit_idx) begin
                valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dtmf_pair_classifier.sv
// Top level: one period meter and one band classifier per tone group; the early
// flag needs both groups accepted, and the code is mapped from the two band indices.
// Assumes tone inputs are clean square waves; CLK_HZ is the reference clock rate.
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 1000000,
    parameter int unsigned AVG_LOG2     = 2,
    parameter int unsigned TOL_PERMILLE = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_low_i,
    input  logic       tone_high_i,
    output logic [3:0] digit_code_o,
    output logic       early_o
);
    localparam int unsigned TO_LOW  = 2 * CLK_HZ / low_hz(0);
    localparam int unsigned TO_HIGH = 2 * CLK_HZ / high_hz(0);
    localparam int unsigned W       = $clog2(TO_LOW + 2) + AVG_LOG2;

    logic [1:0]   tone_in;
    logic [W-1:0] grp_sum [2];
    logic [1:0]   grp_strobe;
    logic [1:0]   grp_timeout;
    logic [3:0]   grp_hit [2];
    logic [1:0]   grp_valid;
    logic [1:0]   grp_idx [2];

    assign tone_in = {tone_high_i, tone_low_i};

    for (genvar g = 0; g < 2; g++) begin : g_grp
        localparam int unsigned TO = (g == 0) ? TO_LOW : TO_HIGH;

        dtmf_period_meter #(
            .TIMEOUT (TO),
            .AVG_LOG2(AVG_LOG2),
            .W       (W)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .tone_i   (tone_in[g]),
            .sum_o    (grp_sum[g]),
            .strobe_o (grp_strobe[g]),
            .timeout_o(grp_timeout[g])
        );

        dtmf_band_classifier #(
            .CLK_HZ      (CLK_HZ),
            .IS_HIGH     (g == 1),
            .AVG_LOG2    (AVG_LOG2),
            .TOL_PERMILLE(TOL_PERMILLE),
            .W           (W)
        ) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .sum_i    (grp_sum[g]),
            .strobe_i (grp_strobe[g]),
            .timeout_i(grp_timeout[g]),
            .hit_o    (grp_hit[g]),
            .valid_o  (grp_valid[g]),
            .idx_o    (grp_idx[g])
        );
    end

    assign early_o      = &grp_valid;
    assign digit_code_o = pair_code(grp_idx[0], grp_idx[1]);
endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
// Property checker for the tone pair classifier, attached by bind.
module dtmf_pair_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       early_o,
    input logic [3:0] digit_code_o,
    input logic [1:0] grp_strobe,
    input logic [1:0] grp_timeout,
    input logic [1:0] grp_valid,
    input logic [3:0] hit_lo,
    input logic [3:0] hit_hi
);
    // R7: code held while the flag stays high
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (early_o && $past(early_o)) |-> $stable(digit_code_o));

    // R6: a timeout of either group forces the flag low next cycle
    p_timeout_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_timeout) |=> !early_o);

    // R5: a group only becomes valid right after an averaged-sum strobe
    p_valid_after_sum_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_valid[0]) |-> $past(grp_strobe[0]));

    p_valid_after_sum_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_valid[1]) |-> $past(grp_strobe[1]));

    // R8: windows within a group never overlap
    p_disjoint_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_lo));

    p_disjoint_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_hi));

    // R3: the flag cannot rise without a strobe in some group
    p_rise_needs_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_o) |-> $past(|grp_strobe));
endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .early_o     (early_o),
    .digit_code_o(digit_code_o),
    .grp_strobe  (grp_strobe),
    .grp_timeout (grp_timeout),
    .grp_valid   (grp_valid),
    .hit_lo      (grp_hit[0]),
    .hit_hi      (grp_hit[1])
);

// File: tb/dtmf_pair_classifier_bench.sv
// Self-checking bench: full digit sweep, window edges, bursts, loss and change.
module dtmf_pair_classifier_bench;
    localparam int unsigned CLK_HZ = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_low_i = 1'b0;
    logic       tone_high_i = 1'b0;
    logic [3:0] digit_code_o;
    logic       early_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    bit en_lo = 1'b0, en_hi = 1'b0;
    int n_lo = 287, n_hi = 165;
    int stab_err = 0;

    always #10 clk = ~clk;

    dtmf_pair_classifier #(.CLK_HZ(CLK_HZ)) u_dtmf_pair_classifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .tone_low_i  (tone_low_i),
        .tone_high_i (tone_high_i),
        .digit_code_o(digit_code_o),
        .early_o     (early_o)
    );

    function automatic int lo_f(input int i);
        int t[4] = '{697, 770, 852, 941};
        return t[i];
    endfunction

    function automatic int hi_f(input int i);
        int t[4] = '{1209, 1336, 1477, 1633};
        return t[i];
    endfunction

    function automatic int nom(input int f);
        return (CLK_HZ + f / 2) / f;
    endfunction

    function automatic int exp_code(input int r, input int c);
        if (c == 3) return (13 + r) % 16;
        if (r < 3) return 3 * r + c + 1;
        if (c == 0) return 11;
        if (c == 1) return 10;
        return 12;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Low-group square wave generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (!en_lo) begin ph = 0; tone_low_i = 1'b0; end
            else begin
                tone_low_i = (ph < n_lo / 2);
                ph = (ph + 1 >= n_lo) ? 0 : ph + 1;
            end
        end
    end

    // High-group square wave generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (!en_hi) begin ph = 0; tone_high_i = 1'b0; end
            else begin
                tone_high_i = (ph < n_hi / 2);
                ph = (ph + 1 >= n_hi) ? 0 : ph + 1;
            end
        end
    end

    // R7 monitor: code must not move while the flag stays high
    initial begin
        logic pe = 1'b0;
        logic [3:0] pc = '0;
        forever begin
            @(negedge clk);
            if (rst_n && early_o && pe && digit_code_o != pc) stab_err++;
            pe = early_o;
            pc = digit_code_o;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gap();
        en_lo = 1'b0; en_hi = 1'b0;
        wait_clk(1500);
    endtask

    // Run a low-group period against nominal 1336 Hz and report the flag
    task automatic edge_case(input int nl, input bit expect_on, input string what);
        gap();
        n_lo = nl; n_hi = nom(1336);
        en_lo = 1'b1; en_hi = 1'b1;
        wait_clk(3000);
        check(early_o == expect_on, what, early_o, expect_on);
    endtask

    initial begin
        int lo_b, hi_b, n_in_lo, n_in_hi;
        bit saw_drop;
        int peak;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check(early_o == 1'b0, "R1 reset flag", early_o, 0);

        // R2/R3: all sixteen pairs at nominal periods
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                n_lo = nom(lo_f(r)); n_hi = nom(hi_f(c));
                en_lo = 1'b1; en_hi = 1'b1;
                wait_clk(3000);
                check(early_o == 1'b1, "R3 pair flag", early_o, 1);
                check(digit_code_o == 4'(exp_code(r, c)), "R2 code", digit_code_o, exp_code(r, c));
                gap();
                check(early_o == 1'b0, "R6 flag after stop", early_o, 0);
            end
        end

        // R3: only one group present
        n_lo = nom(770); en_lo = 1'b1;
        wait_clk(3000);
        check(early_o == 1'b0, "R3 low only", early_o, 0);
        gap();
        n_hi = nom(1477); en_hi = 1'b1;
        wait_clk(3000);
        check(early_o == 1'b0, "R3 high only", early_o, 0);

        // R4: window edges for 852 Hz (sum of 4 periods)
        lo_b = int'((64'(4) * CLK_HZ * 975 + 1000 * 852 - 1) / (1000 * 852));
        hi_b = int'((64'(4) * CLK_HZ * 1025) / (1000 * 852));
        n_in_lo = (lo_b + 3) / 4;
        n_in_hi = hi_b / 4;
        edge_case(n_in_lo, 1'b1, "R4 inside lower edge");
        edge_case(n_in_lo - 1, 1'b0, "R4 outside lower edge");
        edge_case(n_in_hi, 1'b1, "R4 inside upper edge");
        edge_case(n_in_hi + 1, 1'b0, "R4 outside upper edge");

        // R5: burst too short for arming plus four periods
        gap();
        n_lo = nom(697); n_hi = nom(1209);
        en_lo = 1'b1; en_hi = 1'b1;
        peak = 0;
        for (int i = 0; i < 574; i++) begin
            @(negedge clk);
            if (early_o) peak = 1;
        end
        en_lo = 1'b0; en_hi = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (early_o) peak = 1;
        end
        check(peak == 0, "R5 short burst", peak, 0);

        // R6: high group stops while low continues
        n_lo = nom(852); n_hi = nom(1633);
        en_lo = 1'b1; en_hi = 1'b1;
        wait_clk(3000);
        check(early_o == 1'b1, "R6 pre-loss flag", early_o, 1);
        en_hi = 1'b0;
        wait_clk(2 * CLK_HZ / 1209 + 20);
        check(early_o == 1'b0, "R6 high loss", early_o, 0);

        // R7: high frequency change without a gap
        gap();
        n_lo = nom(697); n_hi = nom(1209);
        en_lo = 1'b1; en_hi = 1'b1;
        wait_clk(3000);
        check(digit_code_o == 4'd1, "R7 start code", digit_code_o, 1);
        n_hi = nom(1336);
        saw_drop = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!early_o) saw_drop = 1'b1;
        end
        check(saw_drop, "R7 drop on change", saw_drop, 1);
        check(early_o == 1'b1, "R7 reacquire", early_o, 1);
        check(digit_code_o == 4'd2, "R7 new code", digit_code_o, 2);
        check(stab_err == 0, "R7 code stable while high", stab_err, 0);

        gap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule